// File: doc/BRIEF.md
# Prioritized Nested Interrupt Controller

This block collects six peripheral request lines into four interrupt factors. It selects the one factor that the core should service next. Each factor is a fixed OR of one or more request lines. A rising edge on any of those lines sets the factor's pending latch. The latch stays set until that same factor is accepted. Each factor has its own enable bit and a two-bit priority level. A single master enable gates all acceptance.

When a factor is accepted, the block raises a one-cycle context-save pulse. In the same cycle it presents the factor's vector address, so the core can push its working registers and return address and then branch. Acceptance also clears the master enable and pushes the accepted level onto a small stack of active levels. A request can nest only if its level is strictly above the level on top of that stack. A return strobe pops the stack, sets the master enable again and raises a one-cycle context-restore pulse.

Software reaches the enable bits, the priority levels and the master enable flag through a port-style interface. That interface has a channel select, a write strobe and a combinational read path.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the enable bits, all priority levels and the master enable read 0, no factor is pending and `ctx_save` and `ctx_restore` are low.
- R2: Request bit mapping of `src_req`: bit0 feeds factor 1; bit1 and bit2 feed factor 2; bit2, bit3 and bit4 feed factor 3; bit5 feeds factor 4. A single edge on bit2 makes both factor 2 and factor 3 pending.
- R3: A factor becomes pending on the rising edge of any of its request bits. It stays pending while it is masked or blocked, and it is cleared only when that factor is accepted.
- R4: Channel 0 reads and writes the enable bits: bit k-1 is factor k, 1 permits and 0 masks. A masked factor is never accepted.
- R5: `ei_stb` sets the master enable and `di_stb` clears it, with `ei_stb` winning if both are high. Channel 2 reads the master enable in bit 0. A write to channel 2 changes nothing.
- R6: Acceptance needs the master enable, the factor's enable bit and a pending request. It occurs on the clock edge after the pending latch is set. It raises `ctx_save` for exactly one cycle and clears the master enable. While `ctx_save` is high, `irq_vector` holds 0x10 + 4*(k-1) for factor k.
- R7: A `reti_stb` pulse raises `ctx_restore` for one cycle in the next cycle, sets the master enable and pops one level from the active stack.
- R8: Channel 4 holds the levels of factor 1 (bits 1:0) and factor 2 (bits 3:2). Channel 5 holds the levels of factor 3 (bits 1:0) and factor 4 (bits 3:2). Among eligible factors the highest level wins, and equal levels go to the lower factor number.
- R9: With the active stack non-empty, only a factor whose level is strictly greater than the top level can be accepted. Equal or lower levels stay pending until returns lower the top level or empty the stack.
- R10: No acceptance occurs on a clock edge where `ei_stb`, `di_stb` or `reti_stb` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | 6 | Peripheral request lines, edge sensitive |
| ei_stb | input | 1 | Set master enable |
| di_stb | input | 1 | Clear master enable |
| reti_stb | input | 1 | Return from interrupt |
| port_wr | input | 1 | Register write strobe |
| port_ch | input | 4 | Channel select |
| port_wdata | input | 4 | Write data |
| port_rdata | output | 4 | Read data for the selected channel |
| ctx_save | output | 1 | One-cycle acceptance pulse, request to push context |
| ctx_restore | output | 1 | One-cycle request to restore context |
| irq_vector | output | 8 | Vector of the accepted factor |

## Verification
The assertions assume that every return strobe matches an earlier acceptance, so the active-level stack is never popped empty. They also assume that request lines are low when reset is released. The overflow property depends on the strict level rule, which caps nesting depth at the number of levels. The stimulus keeps every handler bracketed by exactly one return, and it raises request lines only as single-cycle pulses after reset. Master enable strobes are driven either outside any pending window or deliberately on the acceptance edge to probe R10.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
   localparam int LVL_W = 2;
   localparam int CH_W  = 4;
   typedef logic [LVL_W-1:0] lvl_t;
   typedef logic [CH_W-1:0]  ch_t;
   localparam ch_t CH_EN     = 4'd0;
   localparam ch_t CH_ME     = 4'd2;
   localparam ch_t CH_LVL_LO = 4'd4;
endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch #(
   parameter int NSRC = 6,
   parameter int NF   = 4,
   parameter logic [NF*NSRC-1:0] SRC_MAP = {6'b100000, 6'b011100, 6'b000110, 6'b000001}
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src,
   input  logic [NF-1:0]   clr,
   output logic [NF-1:0]   pend
);
   logic [NSRC-1:0] src_q;
   logic [NSRC-1:0] rise;

   initial begin
      a_cfg_src: assert (NSRC > 0 && NF > 0) else $error("irq_src_latch: bad sizes");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_q <= '0;
      else        src_q <= src;
   end

   assign rise = src & ~src_q;

   for (genvar f = 0; f < NF; f++) begin : g_fac
      logic hit;
      logic p_q;
      assign hit = |(rise & SRC_MAP[f*NSRC +: NSRC]);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) p_q <= 1'b0;
         else        p_q <= hit | (p_q & ~clr[f]);
      end
      assign pend[f] = p_q;

      p_hold_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (p_q && !clr[f]) |=> p_q);
   end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
   import prio_irq_pkg::*;
#(
   parameter int NF    = 4,
   parameter int IDX_W = (NF > 1) ? $clog2(NF) : 1
) (
   input  logic [NF-1:0]            pend,
   input  logic [NF-1:0]            en,
   input  logic [NF-1:0][LVL_W-1:0] lvl,
   input  logic                     stk_empty,
   input  lvl_t                     top_lvl,
   output logic                     hit,
   output logic [IDX_W-1:0]         idx,
   output lvl_t                     idx_lvl
);
   always_comb begin
      hit     = 1'b0;
      idx     = '0;
      idx_lvl = '0;
      for (int i = 0; i < NF; i++) begin
         if (pend[i] && en[i] && (stk_empty || lvl[i] > top_lvl)) begin
            if (!hit || lvl[i] > idx_lvl) begin
               hit     = 1'b1;
               idx     = IDX_W'(i);
               idx_lvl = lvl[i];
            end
         end
      end
   end
endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack
   import prio_irq_pkg::*;
#(
   parameter int DEPTH = 4,
   parameter int CNT_W = $clog2(DEPTH + 1),
   parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic push,
   input  logic pop,
   input  lvl_t din,
   output logic empty,
   output lvl_t top
);
   lvl_t             mem [DEPTH];
   logic [CNT_W-1:0] cnt;
   logic             full;

   initial begin
      a_cfg_depth: assert (DEPTH >= 1) else $error("irq_lvl_stack: DEPTH must be positive");
   end

   assign empty = (cnt == '0);
   assign full  = (cnt == CNT_W'(DEPTH));
   assign top   = empty ? '0 : mem[PTR_W'(cnt - 1'b1)];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (push && !full) begin
         mem[PTR_W'(cnt)] <= din;
         cnt              <= cnt + 1'b1;
      end else if (pop && !empty) begin
         cnt <= cnt - 1'b1;
      end
   end

   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   p_nest_rises_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !empty) |-> (din > top));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import prio_irq_pkg::*;
#(
   parameter int NSRC       = 6,
   parameter int NF         = 4,
   parameter int DEPTH      = 4,
   parameter int DATA_W     = 4,
   parameter int VEC_W      = 8,
   parameter int VEC_BASE   = 16,
   parameter int VEC_STRIDE = 4,
   parameter logic [NF*NSRC-1:0] SRC_MAP = {6'b100000, 6'b011100, 6'b000110, 6'b000001}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   src_req,
   input  logic              ei_stb,
   input  logic              di_stb,
   input  logic              reti_stb,
   input  logic              port_wr,
   input  logic [CH_W-1:0]   port_ch,
   input  logic [DATA_W-1:0] port_wdata,
   output logic [DATA_W-1:0] port_rdata,
   output logic              ctx_save,
   output logic              ctx_restore,
   output logic [VEC_W-1:0]  irq_vector
);
   localparam int IDX_W = (NF > 1) ? $clog2(NF) : 1;
   localparam int LPC   = DATA_W / LVL_W;

   initial begin
      a_cfg_width: assert (NF <= DATA_W && LPC >= 1) else $error("prio_irq_ctrl: data port too narrow");
      a_cfg_chan:  assert (int'(CH_LVL_LO) + (NF - 1) / LPC < (1 << CH_W)) else $error("prio_irq_ctrl: too few channels");
   end

   logic [NF-1:0]            en_q;
   logic [NF-1:0][LVL_W-1:0] lvl_q;
   logic                     me_q;
   logic [NF-1:0]            pend;
   logic [NF-1:0]            clr;
   logic                     hit;
   logic [IDX_W-1:0]         idx;
   lvl_t                     idx_lvl;
   logic                     stk_empty;
   lvl_t                     top_lvl;
   logic                     accept;
   logic                     any_stb;

   irq_src_latch #(.NSRC(NSRC), .NF(NF), .SRC_MAP(SRC_MAP)) u_latch (
      .clk(clk), .rst_n(rst_n), .src(src_req), .clr(clr), .pend(pend));

   irq_pick #(.NF(NF)) u_pick (
      .pend(pend), .en(en_q), .lvl(lvl_q), .stk_empty(stk_empty),
      .top_lvl(top_lvl), .hit(hit), .idx(idx), .idx_lvl(idx_lvl));

   irq_lvl_stack #(.DEPTH(DEPTH)) u_stack (
      .clk(clk), .rst_n(rst_n), .push(accept), .pop(reti_stb),
      .din(idx_lvl), .empty(stk_empty), .top(top_lvl));

   assign any_stb = ei_stb | di_stb | reti_stb;
   assign accept  = me_q & hit & ~any_stb;

   always_comb begin
      clr = '0;
      if (accept) clr[idx] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         lvl_q <= '0;
      end else if (port_wr) begin
         if (port_ch == CH_EN) en_q <= port_wdata[NF-1:0];
         for (int f = 0; f < NF; f++) begin
            if (port_ch == ch_t'(int'(CH_LVL_LO) + f / LPC))
               lvl_q[f] <= port_wdata[(f % LPC)*LVL_W +: LVL_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         me_q        <= 1'b0;
         ctx_save    <= 1'b0;
         ctx_restore <= 1'b0;
         irq_vector  <= '0;
      end else begin
         ctx_save    <= accept;
         ctx_restore <= reti_stb;
         if (reti_stb || ei_stb)    me_q <= 1'b1;
         else if (di_stb || accept) me_q <= 1'b0;
         if (accept)
            irq_vector <= VEC_W'(VEC_BASE) + VEC_W'(idx) * VEC_W'(VEC_STRIDE);
      end
   end

   always_comb begin
      port_rdata = '0;
      if (port_ch == CH_EN) port_rdata[NF-1:0] = en_q;
      else if (port_ch == CH_ME) port_rdata[0] = me_q;
      else begin
         for (int f = 0; f < NF; f++) begin
            if (port_ch == ch_t'(int'(CH_LVL_LO) + f / LPC))
               port_rdata[(f % LPC)*LVL_W +: LVL_W] = lvl_q[f];
         end
      end
   end

   p_accept_drops_me_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ctx_save |-> !me_q);
   p_save_needs_me_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ctx_save |-> $past(me_q));
   p_save_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ctx_save |=> !ctx_save);
   p_ret_restores_r7: assert property (@(posedge clk) disable iff (!rst_n)
      reti_stb |=> (me_q && ctx_restore));
   p_ei_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ei_stb |=> me_q);
   p_di_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (di_stb && !ei_stb && !reti_stb) |=> !me_q);
   p_quiet_on_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
      any_stb |=> !ctx_save);
   p_masked_never_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept) |-> en_q[idx]);
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] src_req = '0;
   logic       ei_stb = 1'b0, di_stb = 1'b0, reti_stb = 1'b0;
   logic       port_wr = 1'b0;
   logic [3:0] port_ch = '0, port_wdata = '0;
   logic [3:0] port_rdata;
   logic       ctx_save, ctx_restore;
   logic [7:0] irq_vector;

   int checks = 0;
   int fails  = 0;
   logic [7:0] exp_q[$];

   localparam logic [7:0] V1 = 8'h10, V2 = 8'h14, V3 = 8'h18, V4 = 8'h1C;

   always #2.5 clk = ~clk;

   prio_irq_ctrl u_prio_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .src_req(src_req), .ei_stb(ei_stb),
      .di_stb(di_stb), .reti_stb(reti_stb), .port_wr(port_wr),
      .port_ch(port_ch), .port_wdata(port_wdata), .port_rdata(port_rdata),
      .ctx_save(ctx_save), .ctx_restore(ctx_restore), .irq_vector(irq_vector));

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor: every acceptance pulse must match the oldest expected vector
   always @(negedge clk) begin
      if (rst_n && ctx_save) begin
         if (exp_q.size() == 0) begin
            checks++; fails++;
            $display("FAIL R6: unexpected acceptance, actual vector 0x%0h expected none", irq_vector);
         end else begin
            chk("R6/R8 vector", int'(irq_vector), int'(exp_q.pop_front()));
         end
      end
   end

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic expect_irq(logic [7:0] v);
      exp_q.push_back(v);
   endtask

   task automatic wait_left(int n);
      while (exp_q.size() > n) @(negedge clk);
      tick(1);
   endtask

   task automatic wr(logic [3:0] ch, logic [3:0] d);
      @(posedge clk); #1;
      port_wr = 1'b1; port_ch = ch; port_wdata = d;
      @(posedge clk); #1;
      port_wr = 1'b0;
   endtask

   task automatic rd(logic [3:0] ch, string req, int exp);
      port_ch = ch;
      #1;
      chk(req, int'(port_rdata), exp);
   endtask

   task automatic pulse_src(logic [5:0] m);
      @(posedge clk); #1;
      src_req = m;
      @(posedge clk); #1;
      src_req = '0;
   endtask

   task automatic ei();
      @(posedge clk); #1; ei_stb = 1'b1;
      @(posedge clk); #1; ei_stb = 1'b0;
   endtask

   task automatic di();
      @(posedge clk); #1; di_stb = 1'b1;
      @(posedge clk); #1; di_stb = 1'b0;
   endtask

   task automatic reti();
      @(posedge clk); #1; reti_stb = 1'b1;
      @(posedge clk); #1; reti_stb = 1'b0;
      chk("R7 restore pulse", int'(ctx_restore), 1);
   endtask

   initial begin
      #(5.0 * 100000);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      rd(4'd0, "R1 enables", 0);
      rd(4'd2, "R1 master", 0);
      rd(4'd4, "R1 level lo", 0);
      rd(4'd5, "R1 level hi", 0);
      chk("R1 save idle", int'(ctx_save), 0);
      chk("R1 restore idle", int'(ctx_restore), 0);

      // R4 enables, R8 levels: F1=0 F2=1 F3=2 F4=3
      wr(4'd0, 4'hF);
      rd(4'd0, "R4 enable readback", 15);
      wr(4'd4, 4'b0100);
      wr(4'd5, 4'b1110);
      rd(4'd4, "R8 level lo readback", 4);
      rd(4'd5, "R8 level hi readback", 14);

      // R3/R5: master off holds request pending; channel 2 write ignored
      pulse_src(6'b000001);
      tick(6);
      rd(4'd2, "R5 master still off", 0);
      wr(4'd2, 4'h1);
      rd(4'd2, "R5 write to master ignored", 0);
      expect_irq(V1);
      ei();
      wait_left(0);
      rd(4'd2, "R6 master cleared on accept", 0);
      reti();
      tick(1);
      chk("R7 restore single cycle", int'(ctx_restore), 0);
      rd(4'd2, "R7 master set by return", 1);

      // R2 shared bit2 -> F3 (lvl2) then F2 (lvl1), R8 ordering
      expect_irq(V3); expect_irq(V2);
      pulse_src(6'b000100);
      wait_left(1);
      reti();
      wait_left(0);
      reti();
      // R2 other mappings
      expect_irq(V2); pulse_src(6'b000010); wait_left(0); reti();
      expect_irq(V3); pulse_src(6'b001000); wait_left(0); reti();
      expect_irq(V3); pulse_src(6'b010000); wait_left(0); reti();
      expect_irq(V4); pulse_src(6'b100000); wait_left(0); reti();

      // R8 tie: all level 0, F1 and F4 together -> F1 first
      wr(4'd4, 4'h0); wr(4'd5, 4'h0);
      expect_irq(V1); expect_irq(V4);
      pulse_src(6'b100001);
      wait_left(1);
      reti();
      wait_left(0);
      reti();

      // R9 nesting: F1=1 F2=1 F3=0 F4=3
      wr(4'd4, 4'b0101); wr(4'd5, 4'b1100);
      expect_irq(V1);
      pulse_src(6'b000001);
      wait_left(0);
      ei();
      pulse_src(6'b000010);   // equal level, blocked
      pulse_src(6'b001000);   // lower level, blocked
      tick(6);
      chk("R9 equal/lower blocked", exp_q.size(), 0);
      expect_irq(V4);
      pulse_src(6'b100000);   // higher level nests
      wait_left(0);
      ei();
      tick(6);
      reti();                 // top back to level 1
      tick(6);
      rd(4'd2, "R9 master on while blocked", 1);
      expect_irq(V2); expect_irq(V3);
      reti();                 // stack empty, F2 then F3
      wait_left(1);
      reti();
      wait_left(0);
      reti();

      // R4 masked factor stays pending (R3) until enabled
      wr(4'd0, 4'b0111);
      pulse_src(6'b100000);
      tick(6);
      rd(4'd2, "R4 master untouched while masked", 1);
      expect_irq(V4);
      wr(4'd0, 4'hF);
      wait_left(0);
      reti();

      // R5 DI blocks; EI releases
      di();
      rd(4'd2, "R5 master cleared by DI", 0);
      pulse_src(6'b000001);
      tick(6);
      expect_irq(V1);
      ei();
      chk("R10 no accept on EI edge", int'(ctx_save), 0);
      wait_left(0);
      reti();

      // R10 DI on the would-be acceptance edge
      @(posedge clk); #1; src_req = 6'b000001;
      @(posedge clk); #1; src_req = '0; di_stb = 1'b1;
      @(posedge clk); #1; di_stb = 1'b0;
      chk("R10 no accept on DI edge", int'(ctx_save), 0);
      tick(4);
      rd(4'd2, "R10 master off after DI", 0);
      expect_irq(V1);
      ei();
      wait_left(0);
      reti();
      tick(4);
      chk("R6 scoreboard drained", exp_q.size(), 0);

      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end
endmodule